// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block accepts serial audio on four data lines and delivers eight logical channels of 24-bit samples. It is always a clock slave. The bit clock, the frame clock and the master clock all arrive from outside, and the block drives none of them.

The master clock runs all of the logic. The bit clock and the frame clock are brought into that domain through a two-flop synchronizer. The data lines pass through a synchronizer of the same depth, so they stay aligned with the clocks. Data bits are taken on the rising bit-clock edge. The master clock must run at least eight times faster than the bit clock.

A static format code chooses how the lines are read:

- The three stereo formats (I2S, left-justified and right-justified) give each line one left/right pair.
- One-line mode packs six channels onto line 1 and two onto line 4.
- TDM carries all eight channels on line 1.

A static word-length input (16 to 24 bits) marks where each word sits. Each finished word is sign-extended to 24 bits. It is then presented with a channel index and a one-cycle valid pulse.

Inside the block are two state machines:

- **Frame tracker.** States `ST_PRIME`, `ST_HUNT` and `ST_RUN`.
  - `ST_PRIME` moves to `ST_HUNT` on the first bit-clock event, which records the frame-clock level.
  - `ST_HUNT` moves to `ST_RUN` on the first qualifying frame-clock transition.
  - `ST_RUN` holds until reset.
- **Output drainer.** States `EM_IDLE` and `EM_DRAIN`.
  - `EM_IDLE` moves to `EM_DRAIN` when any line completes a word.
  - `EM_DRAIN` sends one stored word per master-clock cycle.
  - `EM_DRAIN` returns to `EM_IDLE` once nothing is pending and no new word arrives.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is low, smp_valid is 0. After reset, no sample is produced until one qualifying frame-clock transition has been seen. In the stereo formats that is any transition; in one-line and TDM it is a rising one.
- R2: Channel indices are 0..3 for A1..A4 and 4..7 for B1..B4. In the stereo formats, line n (n = 1..4, carried on sdata[n-1]) delivers An in the left half and Bn in the right half.
- R3: In I2S (fmt_sel = 0), frame clock low marks the left half. The MSB arrives one bit clock after the frame-clock transition, and the following bits up to the word length form the word.
- R4: In left-justified mode (fmt_sel = 1), frame clock high marks the left half. The MSB arrives on the first bit clock after the transition.
- R5: In right-justified mode (fmt_sel = 2), frame clock high marks the left half. The LSB is the last bit before the next frame-clock transition, and the word is emitted at that transition.
- R6: In TDM (fmt_sel = 4), line 1 holds eight 32-bit slots starting at the rising frame-clock edge. Slot k goes to channel k, MSB first in each slot. Lines 2, 3 and 4 are ignored.
- R7: In one-line mode (fmt_sel = 3), the 32-bit slots start at the rising frame-clock edge.
  - Line 1, slots 0..5, go to channels 0, 1, 2, 4, 5, 6.
  - Line 4, slots 0 and 1, go to channels 3 and 7.
  - Lines 2 and 3 are ignored.
- R8: Words are two's complement, MSB first, and sign-extended from the word length to 24 bits. A word_len below 16 acts as 16, and one above 24 acts as 24.
- R9: Each sample appears for exactly one cycle with its channel index. Words that finish together are delivered on consecutive cycles in ascending line order, and none is lost.
- R10: Format codes 5, 6 and 7 produce no samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock from the external source |
| fclk | input | 1 | Frame clock at the sample rate |
| sdata | input | 4 | Serial data lines 1..4 (bit 0 is line 1) |
| fmt_sel | input | 3 | Format code: 0 I2S, 1 left-justified, 2 right-justified, 3 one-line, 4 TDM |
| word_len | input | 5 | Word length in bits, clamped to 16..24 |
| smp_valid | output | 1 | One-cycle strobe for a delivered sample |
| smp_chan | output | 3 | Channel index of the sample |
| smp_data | output | 24 | Sign-extended sample |

## Verification
The hardest case to reach from the ports is the right-justified one. There, a word is known to be complete only when the next frame-clock transition arrives, so the final right-half word needs a trailing partial frame to be released at all. Each stereo-format scenario therefore sends a preamble at the opposite frame level, which locks the tracker. It then sends a full frame, and after that a few trailing bits at the left level. The bits outside the word are filled with ones, so bits beyond the word length that leaked into the result would show up as a wrong sign extension. The TDM and one-line frames toggle the ignored lines throughout to show that they never reach an output.

// File: rtl/asrx_pkg.sv
`timescale 1ns/1ps
package asrx_pkg;
    localparam int LANES  = 4;
    localparam int CHANS  = 8;
    localparam int MIN_WL = 16;
    localparam int MAX_WL = 24;
    localparam int SLOT_W = 32;

    typedef enum logic [2:0] {
        FMT_I2S     = 3'd0,
        FMT_LJ      = 3'd1,
        FMT_RJ      = 3'd2,
        FMT_ONELINE = 3'd3,
        FMT_TDM     = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        ST_PRIME,
        ST_HUNT,
        ST_RUN
    } fst_e;

    typedef enum logic {
        EM_IDLE,
        EM_DRAIN
    } est_e;

    typedef logic [MAX_WL-1:0] word_t;

    // Copy bit (wl-1) into every position at or above wl.
    function automatic word_t sext_word(word_t raw, logic [4:0] wl);
        word_t r;
        for (int i = 0; i < MAX_WL; i++) begin
            r[i] = (i < int'(wl)) ? raw[i] : raw[wl - 5'd1];
        end
        return r;
    endfunction
endpackage

// File: rtl/asrx_sync.sv
`timescale 1ns/1ps
module asrx_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-2:0] data_out,
    output logic         rise0
);
    logic [STAGES-1:0][W-1:0] stage_q;
    logic                     last0_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            last0_q <= 1'b0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
            last0_q <= stage_q[STAGES-1][0];
        end
    end

    assign rise0    = stage_q[STAGES-1][0] & ~last0_q;
    assign data_out = stage_q[STAGES-1][W-1:1];
endmodule

// File: rtl/asrx_lane.sv
`timescale 1ns/1ps
module asrx_lane
    import asrx_pkg::*;
#(
    parameter int WL_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_evt,
    input  logic            din,
    input  logic [WL_W-1:0] wl_eff,
    output word_t           held_word,
    output word_t           next_word
);
    word_t shift_q;
    word_t next_raw;

    assign next_raw = {shift_q[MAX_WL-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (bit_evt) begin
            shift_q <= next_raw;
        end
    end

    // Word already in the register (ended on the previous bit).
    assign held_word = sext_word(shift_q, wl_eff);
    // Word that ends with the bit being taken now.
    assign next_word = sext_word(next_raw, wl_eff);
endmodule

// File: rtl/asrx_frame_ctl.sv
`timescale 1ns/1ps
module asrx_frame_ctl
    import asrx_pkg::*;
#(
    parameter int LANES_P   = LANES,
    parameter int SLOT_BITS = SLOT_W,
    parameter int NCHAN     = CHANS,
    parameter int WL_W      = 5
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   bit_evt,
    input  logic                                   fclk_s,
    input  logic [2:0]                             fmt_in,
    input  logic [WL_W-1:0]                        wl_eff,
    output logic [LANES_P-1:0]                     done,
    output logic [LANES_P-1:0][$clog2(NCHAN)-1:0]  done_chan,
    output logic                                   use_held
);
    localparam int SLOT_LG  = $clog2(SLOT_BITS);
    localparam int CH_W     = $clog2(NCHAN);
    localparam int CNT_W    = SLOT_LG + CH_W + 1;
    localparam int OL_SLOTS = 6;
    localparam int OL_SIDE  = 2;

    fst_e state_q, state_d;
    fmt_e fmt;
    logic f_prev;
    logic [CNT_W-1:0] half_q, frame_q, half_pos, frame_pos;
    logic f_edge, f_rise, slot_mode, lock_edge;
    logic [CH_W-1:0] slot_idx;
    logic [SLOT_LG-1:0] slot_bit;
    logic in_frame, slot_hit;

    assign fmt = fmt_e'(fmt_in);

    assign f_edge    = (state_q != ST_PRIME) && (fclk_s != f_prev);
    assign f_rise    = f_edge && fclk_s;
    assign slot_mode = (fmt == FMT_ONELINE) || (fmt == FMT_TDM);
    assign lock_edge = slot_mode ? f_rise : f_edge;

    assign half_pos  = f_edge ? '0 : ((&half_q) ? half_q : half_q + 1'b1);
    assign frame_pos = f_rise ? '0 : ((&frame_q) ? frame_q : frame_q + 1'b1);

    assign slot_idx = frame_pos[SLOT_LG +: CH_W];
    assign slot_bit = frame_pos[SLOT_LG-1:0];
    assign in_frame = ~frame_pos[CNT_W-1];
    assign slot_hit = in_frame && (slot_bit == SLOT_LG'(wl_eff - 1'b1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (bit_evt) state_d = ST_HUNT;
            ST_HUNT:  if (bit_evt && lock_edge) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    // Bit position trackers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_prev  <= 1'b0;
            half_q  <= '1;
            frame_q <= '1;
        end else if (bit_evt) begin
            f_prev  <= fclk_s;
            half_q  <= half_pos;
            frame_q <= frame_pos;
        end
    end

    // Completion decode
    always_comb begin
        done      = '0;
        done_chan = '0;
        use_held  = 1'b0;
        if (state_q == ST_RUN && bit_evt) begin
            unique case (fmt)
                FMT_I2S: begin
                    for (int l = 0; l < LANES_P; l++) begin
                        done[l]      = (half_pos == CNT_W'(wl_eff));
                        done_chan[l] = fclk_s ? CH_W'(l + LANES_P) : CH_W'(l);
                    end
                end
                FMT_LJ: begin
                    for (int l = 0; l < LANES_P; l++) begin
                        done[l]      = (half_pos == CNT_W'(wl_eff - 1'b1));
                        done_chan[l] = fclk_s ? CH_W'(l) : CH_W'(l + LANES_P);
                    end
                end
                FMT_RJ: begin
                    use_held = 1'b1;
                    for (int l = 0; l < LANES_P; l++) begin
                        done[l]      = f_edge;
                        done_chan[l] = f_prev ? CH_W'(l) : CH_W'(l + LANES_P);
                    end
                end
                FMT_TDM: begin
                    done[0]      = slot_hit;
                    done_chan[0] = slot_idx;
                end
                FMT_ONELINE: begin
                    done[0]      = slot_hit && (int'(slot_idx) < OL_SLOTS);
                    done_chan[0] = (int'(slot_idx) < 3) ? slot_idx : slot_idx + 1'b1;
                    done[LANES_P-1]      = slot_hit && (int'(slot_idx) < OL_SIDE);
                    done_chan[LANES_P-1] = (slot_idx == '0) ? CH_W'(LANES_P - 1)
                                                             : CH_W'(NCHAN - 1);
                end
                default: begin
                    done = '0;
                end
            endcase
        end
    end

    // R6
    tdm_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_in == 3'd4) |-> (done[LANES_P-1:1] == '0));

    // R7
    oneline_mid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_in == 3'd3) |-> (done[2:1] == '0));

    // R1
    hunt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (done == '0));

    // R10
    reserved_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_in > 3'd4) |-> (done == '0));
endmodule

// File: rtl/asrx_emit.sv
`timescale 1ns/1ps
module asrx_emit
    import asrx_pkg::*;
#(
    parameter int LANES_P = LANES,
    parameter int CH_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES_P-1:0]            done,
    input  logic [LANES_P-1:0][CH_W-1:0]  done_chan,
    input  logic [LANES_P-1:0][MAX_WL-1:0] done_word,
    output logic                          smp_valid,
    output logic [CH_W-1:0]               smp_chan,
    output logic [MAX_WL-1:0]             smp_data
);
    localparam int PW = (LANES_P > 1) ? $clog2(LANES_P) : 1;

    est_e state_q, state_d;
    logic [LANES_P-1:0] pend_q, pend_d, clr;
    logic [LANES_P-1:0][CH_W-1:0] chan_q;
    logic [LANES_P-1:0][MAX_WL-1:0] word_q;
    logic [PW-1:0] pick;
    logic found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = LANES_P - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick  = PW'(i);
                found = 1'b1;
            end
        end
    end

    assign clr    = (state_q == EM_DRAIN && found) ? (LANES_P'(1) << pick) : '0;
    assign pend_d = (pend_q & ~clr) | done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EM_IDLE:  if (|done) state_d = EM_DRAIN;
            EM_DRAIN: if (pend_d == '0) state_d = EM_IDLE;
            default:  state_d = EM_IDLE;
        endcase
    end

    // Word storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            chan_q <= '0;
            word_q <= '0;
        end else begin
            pend_q <= pend_d;
            for (int i = 0; i < LANES_P; i++) begin
                if (done[i]) begin
                    chan_q[i] <= done_chan[i];
                    word_q[i] <= done_word[i];
                end
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_chan  <= '0;
            smp_data  <= '0;
        end else begin
            smp_valid <= (state_q == EM_DRAIN) && found;
            smp_chan  <= chan_q[pick];
            smp_data  <= word_q[pick];
        end
    end

    // R9
    distinct_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && $past(smp_valid)) |-> (smp_chan != $past(smp_chan)));

    // R9
    drain_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EM_DRAIN && pend_q != '0) |=> smp_valid);
endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx
    import asrx_pkg::*;
#(
    parameter int LANES_P   = LANES,
    parameter int WL_W      = 5,
    parameter int SLOT_BITS = SLOT_W
) (
    input  logic               mclk,
    input  logic               rst_n,
    input  logic               bclk,
    input  logic               fclk,
    input  logic [LANES_P-1:0] sdata,
    input  logic [2:0]         fmt_sel,
    input  logic [WL_W-1:0]    word_len,
    output logic               smp_valid,
    output logic [2:0]         smp_chan,
    output logic [MAX_WL-1:0]  smp_data
);
    localparam int SYNC_W = LANES_P + 2;
    localparam int CH_W   = $clog2(CHANS);

    logic [SYNC_W-2:0] sync_bits;
    logic bit_evt, fclk_s;
    logic [LANES_P-1:0] sdata_s;
    logic [WL_W-1:0] wl_eff;
    logic [LANES_P-1:0] done;
    logic [LANES_P-1:0][CH_W-1:0] done_chan;
    logic use_held;
    logic [LANES_P-1:0][MAX_WL-1:0] held_w, next_w, sel_w;

    asrx_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk      (mclk),
        .rst_n    (rst_n),
        .async_in ({sdata, fclk, bclk}),
        .data_out (sync_bits),
        .rise0    (bit_evt)
    );

    assign fclk_s  = sync_bits[0];
    assign sdata_s = sync_bits[SYNC_W-2:1];

    always_comb begin
        if (word_len < WL_W'(MIN_WL))      wl_eff = WL_W'(MIN_WL);
        else if (word_len > WL_W'(MAX_WL)) wl_eff = WL_W'(MAX_WL);
        else                               wl_eff = word_len;
    end

    asrx_frame_ctl #(
        .LANES_P   (LANES_P),
        .SLOT_BITS (SLOT_BITS),
        .NCHAN     (CHANS),
        .WL_W      (WL_W)
    ) u_frame (
        .clk       (mclk),
        .rst_n     (rst_n),
        .bit_evt   (bit_evt),
        .fclk_s    (fclk_s),
        .fmt_in    (fmt_sel),
        .wl_eff    (wl_eff),
        .done      (done),
        .done_chan (done_chan),
        .use_held  (use_held)
    );

    for (genvar g = 0; g < LANES_P; g++) begin : g_lane
        asrx_lane #(.WL_W(WL_W)) u_lane (
            .clk       (mclk),
            .rst_n     (rst_n),
            .bit_evt   (bit_evt),
            .din       (sdata_s[g]),
            .wl_eff    (wl_eff),
            .held_word (held_w[g]),
            .next_word (next_w[g])
        );
        assign sel_w[g] = use_held ? held_w[g] : next_w[g];
    end

    asrx_emit #(.LANES_P(LANES_P), .CH_W(CH_W)) u_emit (
        .clk       (mclk),
        .rst_n     (rst_n),
        .done      (done),
        .done_chan (done_chan),
        .done_word (sel_w),
        .smp_valid (smp_valid),
        .smp_chan  (smp_chan),
        .smp_data  (smp_data)
    );

    // R8
    sext_out_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        smp_valid |-> (smp_data == sext_word(smp_data, wl_eff)));
endmodule

// File: tb/audio_serial_rx_bench.sv
`timescale 1ns/1ps
module audio_serial_rx_bench;
    logic        mclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic [3:0]  sdata = 4'h0;
    logic [2:0]  fmt_sel = 3'd0;
    logic [4:0]  word_len = 5'd24;
    logic        smp_valid;
    logic [2:0]  smp_chan;
    logic [23:0] smp_data;

    always #2.5 mclk = ~mclk;

    audio_serial_rx u_audio_serial_rx (
        .mclk     (mclk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .fclk     (fclk),
        .sdata    (sdata),
        .fmt_sel  (fmt_sel),
        .word_len (word_len),
        .smp_valid(smp_valid),
        .smp_chan (smp_chan),
        .smp_data (smp_data)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [23:0] got [8];
    int gotcnt [8];
    int order [64];
    int nord = 0;
    logic [23:0] wset [8];

    always @(negedge mclk) begin
        if (smp_valid) begin
            got[smp_chan] = smp_data;
            gotcnt[smp_chan] = gotcnt[smp_chan] + 1;
            if (nord < 64) order[nord] = int'(smp_chan);
            nord = nord + 1;
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] sx(input logic [23:0] w, input int wl);
        logic signed [23:0] t;
        t = $signed(w << (24 - wl));
        return 24'(t >>> (24 - wl));
    endfunction

    function automatic logic nbit(input int f, input logic [23:0] w, input int p, input int wl);
        if (f == 0)      return (p >= 1 && p <= wl) ? w[wl-p] : 1'b1;
        else if (f == 2) return (p >= 32 - wl) ? w[31-p] : 1'b1;
        else             return (p < wl) ? w[wl-1-p] : 1'b1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        bclk = 1'b0;
        for (int c = 0; c < 8; c++) begin
            gotcnt[c] = 0;
            got[c] = '0;
        end
        nord = 0;
        repeat (4) @(negedge mclk);
        rst_n = 1'b1;
        repeat (2) @(negedge mclk);
    endtask

    task automatic send_bit(input logic f, input logic [3:0] d);
        @(negedge mclk);
        fclk = f;
        sdata = d;
        repeat (8) @(negedge mclk);
        bclk = 1'b1;
        repeat (8) @(negedge mclk);
        bclk = 1'b0;
    endtask

    task automatic check_all(input string tag, input int wl);
        for (int c = 0; c < 8; c++) begin
            check_eq({tag, " count"}, gotcnt[c], 1);
            check_eq({tag, " data"}, got[c], sx(wset[c], wl));
        end
        check_eq({tag, " total"}, nord, 8);
    endtask

    // R2 R3 R4 R5 R8 R9: one stereo frame on all four lines
    task automatic run_stereo(input int f, input int wl_set, input int wl_eff, input string tag);
        logic leftlvl;
        logic [3:0] d;
        do_reset();
        fmt_sel = 3'(f);
        word_len = 5'(wl_set);
        leftlvl = (f == 0) ? 1'b0 : 1'b1;
        repeat (4) send_bit(~leftlvl, 4'hF);
        for (int h = 0; h < 2; h++) begin
            for (int p = 0; p < 32; p++) begin
                for (int l = 0; l < 4; l++) d[l] = nbit(f, wset[l + 4*h], p, wl_eff);
                send_bit((h == 0) ? leftlvl : ~leftlvl, d);
            end
        end
        repeat (4) send_bit(leftlvl, 4'h0);
        repeat (40) @(negedge mclk);
        check_all({tag, " R2"}, wl_eff);
        for (int k = 0; k < 4; k++) check_eq({tag, " R9 order"}, order[k], k);
    endtask

    // R6: TDM frame, lines 2..4 toggling
    task automatic run_tdm(input int wl);
        logic [3:0] d;
        do_reset();
        fmt_sel = 3'd4;
        word_len = 5'(wl);
        repeat (4) send_bit(1'b0, 4'hE);
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 32; p++) begin
                d[0] = (p < wl) ? wset[s][wl-1-p] : 1'b1;
                d[3:1] = {p[0], s[0], ~p[1]};
                send_bit(s < 4, d);
            end
        end
        repeat (4) send_bit(1'b1, 4'h0);
        repeat (40) @(negedge mclk);
        check_all("R6 tdm", wl);
    endtask

    // R7: one-line frame
    task automatic run_oneline(input int wl);
        logic [3:0] d;
        int cm;
        do_reset();
        fmt_sel = 3'd3;
        word_len = 5'(wl);
        repeat (4) send_bit(1'b0, 4'h6);
        for (int s = 0; s < 6; s++) begin
            cm = (s < 3) ? s : s + 1;
            for (int p = 0; p < 32; p++) begin
                d[0] = (p < wl) ? wset[cm][wl-1-p] : 1'b1;
                d[2:1] = {p[0], ~p[0]};
                if (s < 2) d[3] = (p < wl) ? wset[(s == 0) ? 3 : 7][wl-1-p] : 1'b1;
                else       d[3] = p[1];
                send_bit(s < 3, d);
            end
        end
        repeat (4) send_bit(1'b1, 4'h0);
        repeat (40) @(negedge mclk);
        check_all("R7 oneline", wl);
    endtask

    // R1: no frame edge, no samples
    task automatic run_hunt();
        do_reset();
        check_eq("R1 valid after reset", smp_valid, 0);
        fmt_sel = 3'd1;
        word_len = 5'd16;
        for (int p = 0; p < 70; p++) send_bit(1'b1, 4'(p));
        repeat (40) @(negedge mclk);
        check_eq("R1 hunt silent", nord, 0);
    endtask

    // R10: reserved format codes
    task automatic run_reserved(input int f);
        logic [3:0] d;
        do_reset();
        fmt_sel = 3'(f);
        word_len = 5'd16;
        repeat (4) send_bit(1'b0, 4'hF);
        for (int h = 0; h < 2; h++) begin
            for (int p = 0; p < 32; p++) begin
                for (int l = 0; l < 4; l++) d[l] = nbit(1, wset[l + 4*h], p, 16);
                send_bit(h == 0, d);
            end
        end
        repeat (4) send_bit(1'b1, 4'h0);
        repeat (40) @(negedge mclk);
        check_eq("R10 reserved silent", nord, 0);
    endtask

    initial begin
        wset[0] = 24'h9A5C3E; wset[1] = 24'h1234F0; wset[2] = 24'hFEDCBA; wset[3] = 24'h7FFFFF;
        wset[4] = 24'h800001; wset[5] = 24'h3C3C3C; wset[6] = 24'hC0FFEE; wset[7] = 24'h05A5A5;
        #1;
        check_eq("R1 valid in reset", smp_valid, 0);
        run_hunt();
        run_stereo(0, 24, 24, "R3 i2s24");
        run_stereo(0, 18, 18, "R3 i2s18");
        run_stereo(1, 20, 20, "R4 lj20");
        run_stereo(1, 10, 16, "R8 lj clamp-low");
        run_stereo(2, 16, 16, "R5 rj16");
        run_stereo(2, 30, 24, "R8 rj clamp-high");
        run_tdm(24);
        run_tdm(16);
        run_oneline(20);
        run_reserved(5);
        run_reserved(7);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge mclk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule